// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit linear address into a 32-bit physical address. It reads a page directory entry and, for an ordinary 4 KB page, a page table entry from memory. A directory entry with its large-page bit set ends the walk after one read and maps a 4 MB region. Each request says whether the access is a read, a write or an instruction fetch, and whether it comes from user or supervisor mode. The walker checks the permission bits of the entries it used. On success it sets the accessed bit, and on a write it also sets the dirty bit in the leaf entry. It then returns the physical address. A missing entry or a refused access ends the walk with a fault response that describes the failure.

The walker handles one translation at a time. It accepts a request only when it is idle and answers with a single-cycle response. All entry fetches and entry write-backs use one memory port with a request/acknowledge handshake. The page directory is located by a frame number input that the surrounding logic holds steady.

Top module: `pt_walker`

## Requirements
- R1: While reset is held and right after it, the walker is idle: `req_ready_o` is 1, and `rsp_valid_o` and `mem_req_o` are 0.
- R2: The directory entry is read from `{dir_frame_i, va[31:22], 2'b00}`. For a 4 KB page, the table entry is read from `{pde[31:12], va[21:12], 2'b00}`.
- R3: For a 4 KB page the result is `{pte[31:12], va[11:0]}`.
- R4: When directory entry bit 7 is set, the result is `{pde[31:22], va[21:0]}` and no table entry is read.
- R5: When the present bit (bit 0) of the directory or table entry is 0, the walk faults with `rsp_fcause_o`=0 and `rsp_flevel_o`=0 (directory) or 1 (table). The access kind and the mode are echoed on `rsp_kind_o` and `rsp_user_o`.
- R6: A user access (`req_user_i`=1) faults with `rsp_fcause_o`=1 unless the user bit (bit 2) is set in every entry used. The fault level is 0 for a 4 MB page and 1 for a 4 KB page.
- R7: A user write (`req_kind_i`=1) faults with `rsp_fcause_o`=1 unless the write bit (bit 1) is set in every entry used. Supervisor accesses ignore the write bit. Kind 0 is a read, kind 2 is a fetch, and kind 3 is handled as a read.
- R8: On success the leaf entry gets its accessed bit (bit 5) set, and on a write also its dirty bit (bit 6). On a 4 KB walk the directory entry gets only its accessed bit set.
- R9: An entry is written back only if its value changes. The directory entry is written before the table entry. A faulting walk writes nothing.
- R10: `rsp_valid_o` is high for exactly one cycle per request. On the next cycle the walker is idle again with `req_ready_o`=1.
- R11: A memory request keeps its address, write enable and data stable until `mem_ack_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dir_frame_i | input | 20 | Frame number of the page directory |
| req_valid_i | input | 1 | Translation request |
| req_ready_o | output | 1 | Walker idle, request accepted |
| req_vaddr_i | input | 32 | Linear address |
| req_kind_i | input | 2 | 0 read, 1 write, 2 fetch |
| req_user_i | input | 1 | 1 for a user-mode access |
| rsp_valid_o | output | 1 | Response pulse |
| rsp_fault_o | output | 1 | Walk ended in a page fault |
| rsp_paddr_o | output | 32 | Physical address (success only) |
| rsp_flevel_o | output | 1 | Fault level: 0 directory, 1 table |
| rsp_fcause_o | output | 1 | 0 not present, 1 protection |
| rsp_kind_o | output | 2 | Access kind of the answered request |
| rsp_user_o | output | 1 | Mode of the answered request |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | Memory access is a write |
| mem_addr_o | output | 32 | Byte address of the entry |
| mem_wdata_o | output | 32 | Entry value to write |
| mem_ack_i | input | 1 | Memory access complete, read data valid |
| mem_rdata_i | input | 32 | Entry read from memory |

## Verification
The bench targets a supervisor write to a read-only page. A walker that applies the write check in every mode would fault there instead of setting the dirty bit. It also covers leaf entries whose accessed and dirty bits are already set, where a walker without change detection would issue needless writes. Large pages are driven with fetches and writes: a walker that ignores bit 7 would read a bogus second-level entry, and one that sets the dirty bit on fetches would corrupt the entry. A missing table entry tests the fault level reporting. Random directory and table contents, mixed with random memory latency, cover the combined permission rule and the ordering of write-backs.

// File: rtl/pt_walker_pkg.sv
package pt_walker_pkg;
    localparam int AW          = 32;
    localparam int OFF_W       = 12;
    localparam int IDX_W       = 10;
    localparam int FRAME_W     = AW - OFF_W;
    localparam int BIG_OFF_W   = OFF_W + IDX_W;
    localparam int BIG_FRAME_W = AW - BIG_OFF_W;

    localparam int B_P  = 0;
    localparam int B_RW = 1;
    localparam int B_US = 2;
    localparam int B_A  = 5;
    localparam int B_D  = 6;
    localparam int B_PS = 7;

    localparam logic [1:0] ACC_READ  = 2'd0;
    localparam logic [1:0] ACC_WRITE = 2'd1;
    localparam logic [1:0] ACC_FETCH = 2'd2;

    localparam logic CAUSE_NP   = 1'b0;
    localparam logic CAUSE_PROT = 1'b1;

    typedef enum logic [2:0] {
        S_IDLE,
        S_READ_PDE,
        S_READ_PTE,
        S_UPDATE_AD,
        S_DONE,
        S_FAULT
    } walk_state_e;

    typedef struct packed {
        walk_state_e          state;
        logic [AW-1:0]        va;
        logic [1:0]           kind;
        logic                 user;
        logic [FRAME_W-1:0]   base;
        logic [AW-1:0]        pde;
        logic [AW-1:0]        pde_new;
        logic [AW-1:0]        pte_new;
        logic                 pde_wr;
        logic                 pte_wr;
        logic [AW-1:0]        paddr;
        logic                 flevel;
        logic                 fcause;
    } walk_regs_t;
endpackage

// File: rtl/pt_walker_perm.sv
module pt_walker_perm (
    input  logic rw_ok_i,
    input  logic us_ok_i,
    input  logic is_write_i,
    input  logic is_user_i,
    output logic allow_o
);
    logic user_block;
    logic write_block;

    always_comb begin
        user_block  = is_user_i && !us_ok_i;
        write_block = is_user_i && is_write_i && !rw_ok_i;
        allow_o     = !user_block && !write_block;
    end
endmodule

// File: rtl/pt_walker_adupd.sv
module pt_walker_adupd #(
    parameter int W     = 32,
    parameter int A_BIT = 5,
    parameter int D_BIT = 6
) (
    input  logic [W-1:0] entry_i,
    input  logic         set_dirty_i,
    output logic [W-1:0] entry_o,
    output logic         changed_o
);
    logic [W-1:0] set_mask;

    always_comb begin
        set_mask        = '0;
        set_mask[A_BIT] = 1'b1;
        set_mask[D_BIT] = set_dirty_i;
        entry_o         = entry_i | set_mask;
        changed_o       = (entry_o != entry_i);
    end
endmodule

// File: rtl/pt_walker_addr.sv
module pt_walker_addr
    import pt_walker_pkg::*;
(
    input  logic [FRAME_W-1:0] base_i,
    input  logic [AW-1:0]      va_i,
    input  logic [AW-1:0]      pde_i,
    input  logic [AW-1:0]      rdata_i,
    output logic [AW-1:0]      pde_addr_o,
    output logic [AW-1:0]      pte_addr_o,
    output logic [AW-1:0]      paddr_small_o,
    output logic [AW-1:0]      paddr_big_o
);
    localparam int ESZ_W = OFF_W - IDX_W;

    always_comb begin
        pde_addr_o    = {base_i, va_i[AW-1 -: IDX_W], {ESZ_W{1'b0}}};
        pte_addr_o    = {pde_i[AW-1 -: FRAME_W], va_i[BIG_OFF_W-1 -: IDX_W], {ESZ_W{1'b0}}};
        paddr_small_o = {rdata_i[AW-1 -: FRAME_W], va_i[OFF_W-1:0]};
        paddr_big_o   = {rdata_i[AW-1 -: BIG_FRAME_W], va_i[BIG_OFF_W-1:0]};
    end
endmodule

// File: rtl/pt_walker.sv
module pt_walker
    import pt_walker_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [FRAME_W-1:0]  dir_frame_i,
    input  logic                req_valid_i,
    output logic                req_ready_o,
    input  logic [AW-1:0]       req_vaddr_i,
    input  logic [1:0]          req_kind_i,
    input  logic                req_user_i,
    output logic                rsp_valid_o,
    output logic                rsp_fault_o,
    output logic [AW-1:0]       rsp_paddr_o,
    output logic                rsp_flevel_o,
    output logic                rsp_fcause_o,
    output logic [1:0]          rsp_kind_o,
    output logic                rsp_user_o,
    output logic                mem_req_o,
    output logic                mem_we_o,
    output logic [AW-1:0]       mem_addr_o,
    output logic [AW-1:0]       mem_wdata_o,
    input  logic                mem_ack_i,
    input  logic [AW-1:0]       mem_rdata_i
);
    walk_regs_t q, d;

    logic          is_write;
    logic [AW-1:0] pde_addr, pte_addr, paddr_small, paddr_big;
    logic          big_ok, small_ok;
    logic [AW-1:0] big_new, dir_new, tab_new;
    logic          big_chg, dir_chg, tab_chg;

    assign is_write = (q.kind == ACC_WRITE);

    pt_walker_addr u_addr (
        .base_i        (q.base),
        .va_i          (q.va),
        .pde_i         (q.pde),
        .rdata_i       (mem_rdata_i),
        .pde_addr_o    (pde_addr),
        .pte_addr_o    (pte_addr),
        .paddr_small_o (paddr_small),
        .paddr_big_o   (paddr_big)
    );

    pt_walker_perm u_perm_big (
        .rw_ok_i    (mem_rdata_i[B_RW]),
        .us_ok_i    (mem_rdata_i[B_US]),
        .is_write_i (is_write),
        .is_user_i  (q.user),
        .allow_o    (big_ok)
    );

    pt_walker_perm u_perm_small (
        .rw_ok_i    (q.pde[B_RW] & mem_rdata_i[B_RW]),
        .us_ok_i    (q.pde[B_US] & mem_rdata_i[B_US]),
        .is_write_i (is_write),
        .is_user_i  (q.user),
        .allow_o    (small_ok)
    );

    pt_walker_adupd #(.W(AW), .A_BIT(B_A), .D_BIT(B_D)) u_ad_big (
        .entry_i     (mem_rdata_i),
        .set_dirty_i (is_write),
        .entry_o     (big_new),
        .changed_o   (big_chg)
    );

    pt_walker_adupd #(.W(AW), .A_BIT(B_A), .D_BIT(B_D)) u_ad_dir (
        .entry_i     (q.pde),
        .set_dirty_i (1'b0),
        .entry_o     (dir_new),
        .changed_o   (dir_chg)
    );

    pt_walker_adupd #(.W(AW), .A_BIT(B_A), .D_BIT(B_D)) u_ad_tab (
        .entry_i     (mem_rdata_i),
        .set_dirty_i (is_write),
        .entry_o     (tab_new),
        .changed_o   (tab_chg)
    );

    always_comb begin
        d = q;
        unique case (q.state)
            S_IDLE: begin
                if (req_valid_i) begin
                    d.va     = req_vaddr_i;
                    d.kind   = req_kind_i;
                    d.user   = req_user_i;
                    d.base   = dir_frame_i;
                    d.pde_wr = 1'b0;
                    d.pte_wr = 1'b0;
                    d.state  = S_READ_PDE;
                end
            end
            S_READ_PDE: begin
                if (mem_ack_i) begin
                    d.pde = mem_rdata_i;
                    if (!mem_rdata_i[B_P]) begin
                        d.flevel = 1'b0;
                        d.fcause = CAUSE_NP;
                        d.state  = S_FAULT;
                    end else if (mem_rdata_i[B_PS]) begin
                        if (!big_ok) begin
                            d.flevel = 1'b0;
                            d.fcause = CAUSE_PROT;
                            d.state  = S_FAULT;
                        end else begin
                            d.pde_new = big_new;
                            d.pde_wr  = big_chg;
                            d.paddr   = paddr_big;
                            d.state   = big_chg ? S_UPDATE_AD : S_DONE;
                        end
                    end else begin
                        d.state = S_READ_PTE;
                    end
                end
            end
            S_READ_PTE: begin
                if (mem_ack_i) begin
                    if (!mem_rdata_i[B_P]) begin
                        d.flevel = 1'b1;
                        d.fcause = CAUSE_NP;
                        d.state  = S_FAULT;
                    end else if (!small_ok) begin
                        d.flevel = 1'b1;
                        d.fcause = CAUSE_PROT;
                        d.state  = S_FAULT;
                    end else begin
                        d.pde_new = dir_new;
                        d.pde_wr  = dir_chg;
                        d.pte_new = tab_new;
                        d.pte_wr  = tab_chg;
                        d.paddr   = paddr_small;
                        d.state   = (dir_chg || tab_chg) ? S_UPDATE_AD : S_DONE;
                    end
                end
            end
            S_UPDATE_AD: begin
                if (mem_ack_i) begin
                    if (q.pde_wr) begin
                        d.pde_wr = 1'b0;
                        d.state  = q.pte_wr ? S_UPDATE_AD : S_DONE;
                    end else begin
                        d.pte_wr = 1'b0;
                        d.state  = S_DONE;
                    end
                end
            end
            S_DONE:  d.state = S_IDLE;
            S_FAULT: d.state = S_IDLE;
            default: d.state = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        req_ready_o  = (q.state == S_IDLE);
        rsp_valid_o  = (q.state == S_DONE) || (q.state == S_FAULT);
        rsp_fault_o  = (q.state == S_FAULT);
        rsp_paddr_o  = q.paddr;
        rsp_flevel_o = q.flevel;
        rsp_fcause_o = q.fcause;
        rsp_kind_o   = q.kind;
        rsp_user_o   = q.user;
        mem_req_o    = (q.state == S_READ_PDE) || (q.state == S_READ_PTE) ||
                       (q.state == S_UPDATE_AD);
        mem_we_o     = (q.state == S_UPDATE_AD);
        mem_addr_o   = pde_addr;
        mem_wdata_o  = '0;
        if (q.state == S_READ_PTE) begin
            mem_addr_o = pte_addr;
        end else if (q.state == S_UPDATE_AD) begin
            mem_addr_o  = q.pde_wr ? pde_addr : pte_addr;
            mem_wdata_o = q.pde_wr ? q.pde_new : q.pte_new;
        end
    end

    // R10: response lasts one cycle
    p_rsp_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid_o |=> !rsp_valid_o && req_ready_o);

    // R10: idle never overlaps a memory access or a response
    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready_o |-> !mem_req_o && !rsp_valid_o);

    // R11: request held stable until acknowledged
    p_mem_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && !mem_ack_i) |=> mem_req_o && $stable(mem_addr_o) &&
                                      $stable(mem_we_o) && $stable(mem_wdata_o));

    // R8: every write-back carries the accessed bit
    p_wb_accessed_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && mem_we_o) |-> mem_wdata_o[B_A]);

    // R9: a fault is never preceded by a write-back in the same walk
    p_fault_nowrite_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid_o && rsp_fault_o) |-> !$past(mem_we_o));

    // R4: a large-page walk never issues a table read after the directory read
    p_big_no_pte_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && !mem_we_o && mem_addr_o != pde_addr) |-> !q.pde[B_PS]);
endmodule

// File: tb/test_pt_walker.sv
`timescale 1ns/1ps
module test_pt_walker;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [19:0] dir_frame_i;
    logic        req_valid_i;
    logic        req_ready_o;
    logic [31:0] req_vaddr_i;
    logic [1:0]  req_kind_i;
    logic        req_user_i;
    logic        rsp_valid_o, rsp_fault_o, rsp_flevel_o, rsp_fcause_o, rsp_user_o;
    logic [31:0] rsp_paddr_o;
    logic [1:0]  rsp_kind_o;
    logic        mem_req_o, mem_we_o, mem_ack_i;
    logic [31:0] mem_addr_o, mem_wdata_o, mem_rdata_i;

    always #10 clk = ~clk;

    pt_walker i_pt_walker (
        .clk(clk), .rst_n(rst_n), .dir_frame_i(dir_frame_i),
        .req_valid_i(req_valid_i), .req_ready_o(req_ready_o),
        .req_vaddr_i(req_vaddr_i), .req_kind_i(req_kind_i), .req_user_i(req_user_i),
        .rsp_valid_o(rsp_valid_o), .rsp_fault_o(rsp_fault_o), .rsp_paddr_o(rsp_paddr_o),
        .rsp_flevel_o(rsp_flevel_o), .rsp_fcause_o(rsp_fcause_o),
        .rsp_kind_o(rsp_kind_o), .rsp_user_o(rsp_user_o),
        .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
        .mem_wdata_o(mem_wdata_o), .mem_ack_i(mem_ack_i), .mem_rdata_i(mem_rdata_i)
    );

    localparam logic [19:0] PD_FRAME = 20'h00001;

    logic [31:0] mem [logic [31:0]];
    int total = 0;
    int bad = 0;
    int wr_cnt = 0;
    logic [31:0] first_wr = '0;

    function automatic logic [31:0] rd(input logic [31:0] a);
        return mem.exists(a) ? mem[a] : 32'h0;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // memory model with random latency, driven at falling edges
    initial begin
        int wait_cnt = 0;
        int lat = 1;
        mem_ack_i   = 1'b0;
        mem_rdata_i = '0;
        forever begin
            @(negedge clk);
            if (mem_ack_i) begin
                mem_ack_i = 1'b0;
            end else if (mem_req_o) begin
                if (wait_cnt < lat) begin
                    wait_cnt++;
                end else begin
                    if (mem_we_o) begin
                        mem[mem_addr_o] = mem_wdata_o;
                        if (wr_cnt == 0) first_wr = mem_addr_o;
                        wr_cnt++;
                    end else begin
                        mem_rdata_i = rd(mem_addr_o);
                    end
                    mem_ack_i = 1'b1;
                    wait_cnt  = 0;
                    lat       = $urandom % 3;
                end
            end
        end
    end

    task automatic run(input logic [31:0] va, input logic [1:0] kind, input logic user,
                       input logic [31:0] pde, input logic [31:0] pte, input string tag);
        logic [31:0] pdea, ptea, exp_pde, exp_pte, exp_pa, exp_first;
        logic        big, wr, exp_fault, exp_lvl, exp_cause, rwok, usok, uviol;
        int          exp_w, n;
        string       lbl;
        pdea = {PD_FRAME, va[31:22], 2'b00};
        ptea = {pde[31:12], va[21:12], 2'b00};
        big  = pde[7];
        wr   = (kind == 2'd1);
        mem[pdea] = pde;
        if (!big) mem[ptea] = pte;
        exp_pde = pde; exp_pte = pte; exp_pa = '0; exp_w = 0; exp_first = '0;
        exp_fault = 1'b0; exp_lvl = 1'b0; exp_cause = 1'b0; uviol = 1'b0;
        if (!pde[0]) begin
            exp_fault = 1'b1;
        end else if (big) begin
            uviol = user && !pde[2];
            if (uviol || (user && wr && !pde[1])) begin
                exp_fault = 1'b1; exp_cause = 1'b1;
            end else begin
                exp_pde = pde | 32'h20 | (wr ? 32'h40 : 32'h0);
                exp_pa  = {pde[31:22], va[21:0]};
                exp_w   = (exp_pde != pde) ? 1 : 0;
                exp_first = pdea;
            end
        end else if (!pte[0]) begin
            exp_fault = 1'b1; exp_lvl = 1'b1;
        end else begin
            rwok  = pde[1] & pte[1];
            usok  = pde[2] & pte[2];
            uviol = user && !usok;
            if (uviol || (user && wr && !rwok)) begin
                exp_fault = 1'b1; exp_lvl = 1'b1; exp_cause = 1'b1;
            end else begin
                exp_pde = pde | 32'h20;
                exp_pte = pte | 32'h20 | (wr ? 32'h40 : 32'h0);
                exp_pa  = {pte[31:12], va[11:0]};
                exp_w   = ((exp_pde != pde) ? 1 : 0) + ((exp_pte != pte) ? 1 : 0);
                exp_first = (exp_pde != pde) ? pdea : ptea;
            end
        end
        if (exp_fault) lbl = exp_cause ? (uviol ? "R6" : "R7") : "R5";
        else           lbl = big ? "R4" : "R3";

        wr_cnt = 0;
        first_wr = '0;
        @(negedge clk);
        req_valid_i = 1'b1; req_vaddr_i = va; req_kind_i = kind; req_user_i = user;
        @(negedge clk);
        req_valid_i = 1'b0;
        n = 0;
        while (!rsp_valid_o && n < 200) begin
            @(negedge clk);
            n++;
        end
        check({lbl, " ", tag, " response seen (R10)"}, {31'd0, rsp_valid_o}, 32'd1);
        check({lbl, " ", tag, " fault flag"}, {31'd0, rsp_fault_o}, {31'd0, exp_fault});
        if (exp_fault) begin
            check({lbl, " ", tag, " fault level"}, {31'd0, rsp_flevel_o}, {31'd0, exp_lvl});
            check({lbl, " ", tag, " fault cause"}, {31'd0, rsp_fcause_o}, {31'd0, exp_cause});
            check({"R5 ", tag, " kind and mode echo"}, {29'd0, rsp_kind_o, rsp_user_o},
                  {29'd0, kind, user});
        end else begin
            check({lbl, " ", tag, " paddr (R2 addressing)"}, rsp_paddr_o, exp_pa);
        end
        check({"R8 ", tag, " directory entry in memory"}, rd(pdea), exp_pde);
        if (!big) check({"R8 ", tag, " table entry in memory"}, rd(ptea), exp_pte);
        check({"R9 ", tag, " write-back count"}, wr_cnt, exp_w);
        if (exp_w > 0) check({"R9 ", tag, " first write-back address"}, first_wr, exp_first);
        @(negedge clk);
        check({"R10 ", tag, " single-cycle response"}, {30'd0, rsp_valid_o, req_ready_o}, 32'd1);
    endtask

    initial begin
        rst_n = 1'b0;
        dir_frame_i = PD_FRAME;
        req_valid_i = 1'b0; req_vaddr_i = '0; req_kind_i = '0; req_user_i = 1'b0;
        void'($urandom(32'd20251));
        repeat (3) @(negedge clk);
        check("R1 ready in reset", {31'd0, req_ready_o}, 32'd1);
        check("R1 no response in reset", {31'd0, rsp_valid_o}, 32'd0);
        check("R1 no memory request in reset", {31'd0, mem_req_o}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 idle after reset", {30'd0, req_ready_o, mem_req_o}, 32'd2);

        // R7: supervisor write to read-only 4 KB page succeeds and sets dirty
        run(32'h0040_3abc, 2'd1, 1'b0, 32'h0050_0005, 32'h1234_5005, "sup write ro");
        // R9: everything already set, no write-back
        run(32'h0040_4010, 2'd0, 1'b1, 32'h0050_0027, 32'h2222_2067, "no change");
        // R7: user write to read-only large page faults at level 0
        run(32'h0c12_3456, 2'd1, 1'b1, 32'h8000_0085, 32'h0, "big user write ro");
        // R4: fetch from large page sets accessed only
        run(32'h0d2a_bcde, 2'd2, 1'b1, 32'h4440_0087, 32'h0, "big fetch");
        // R4: write to large page sets accessed and dirty
        run(32'h0e00_0fff, 2'd1, 1'b0, 32'hffc0_0083, 32'h0, "big write");
        // R5: missing table entry faults at level 1
        run(32'h0041_5000, 2'd1, 1'b1, 32'h0051_0007, 32'h7777_7006, "pte absent");
        // R5: missing directory entry
        run(32'hfff0_0000, 2'd2, 1'b0, 32'h0051_0006, 32'h0, "pde absent");
        // R6: user read with table user bit clear
        run(32'h0042_6123, 2'd0, 1'b1, 32'h0052_0007, 32'h3333_3003, "user denied");

        for (int i = 0; i < 300; i++) begin
            logic [31:0] va, pde, pte;
            logic [1:0]  kind;
            va   = $urandom;
            kind = 2'($urandom % 4);
            pde  = $urandom;
            pde[0] = ($urandom % 10) != 0;
            pde[7] = ($urandom % 3) == 0;
            if (!pde[7]) pde[31:12] = 20'h00400 + 20'($urandom % 256);
            pte  = $urandom;
            pte[0] = ($urandom % 10) != 0;
            run(va, kind, 1'($urandom % 2), pde, pte, "random");
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog R10 actual=hung expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule